// File: doc/BRIEF.md
# Tri-level PWM command decoder

This block sits between two window comparators on a half-bridge control line and the gate-drive sequencer. One comparator flag reports that the control voltage is above the lower window edge; the other reports that it is below the upper window edge. From these two flags the block produces one of three commands: drive the low-side switch, drive the high-side switch, or turn both switches off.

The off command exists so that a controller can park the power stage. It does this by holding the control line at a mid level, inside the window. A short trip through the window, which is what an ordinary edge looks like, keeps the previous command. The line must stay inside the window for a programmable number of clock cycles before the block declares the off state. Leaving the window ends the off state at once.

A supply-monitor gate keeps both switches off until the supply has risen past a release level. It then keeps the stage enabled until the supply falls below a lower hold level. All four flags are asynchronous and pass through a two-flop synchronizer inside the block. The command is a plain level output with no handshake. The downstream sequencer samples it every cycle and cannot apply back-pressure.

Top module: `tri_pwm_decoder`

## Requirements
- R1: The `cmd` output encodes 2'b00 for low-side on, 2'b01 for high-side on and 2'b10 for both off. `hs_on` is 1 only for 2'b01, `ls_on` is 1 only for 2'b00, and the two are never 1 together.
- R2: The control line is classed from the flags as follows. The low region is `cmp_above_lo`=0 with `cmp_below_hi`=1. The high region is `cmp_above_lo`=1 with `cmp_below_hi`=0. The window is both flags at 1. A move into the low or high region appears on `cmd` after exactly three rising clock edges.
- R3: While the line is in the window, `cmd` keeps its previous low or high value. This is the hysteresis between the two thresholds. `cmd` becomes 2'b10 only after HOLD_CYC consecutive window samples, which puts it HOLD_CYC+2 edges after the line enters the window. A window stay of HOLD_CYC-1 cycles leaves `cmd` unchanged.
- R4: Any sample outside the window restarts the holdoff count from zero.
- R5: The off state ends with no holdoff. A move to the low or high region shows up on `cmd` with the same three-edge latency as R2.
- R6: The impossible flag pair (`cmp_above_lo`=0, `cmp_below_hi`=0) leaves `cmd` unchanged and restarts the holdoff count.
- R7: While `rst_n` is low, and after reset until the supply gate releases, `cmd` is 2'b10 and both enables are 0.
- R8: The supply gate releases when the synchronized `sup_above_rel` is 1. Once released, it stays released while `sup_above_hold` is 1, whatever the value of `sup_above_rel`. When `sup_above_hold` drops, `cmd` becomes 2'b10 three edges later.
- R9: On release, `cmd` shows 2'b10 for one further edge and then follows the line. If the line is in the window at release, `cmd` stays 2'b10 until the line leaves the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_above_lo | input | 1 | Control line above lower window edge (async) |
| cmp_below_hi | input | 1 | Control line below upper window edge (async) |
| sup_above_rel | input | 1 | Supply above release level (async) |
| sup_above_hold | input | 1 | Supply above hold level (async) |
| cmd | output | 2 | Command code: 00 low-side, 01 high-side, 10 off |
| hs_on | output | 1 | High-side switch enable |
| ls_on | output | 1 | Low-side switch enable |

## Verification
Holdoff expiry and the supply gate dropping out can land on the same clock edge. Both drive the command to off, but through separate paths. The bench times a hold-flag drop so that it reaches the gate on exactly the edge where the window count expires. It requires the off code at that edge and afterwards. After re-release with the line still in the window, `cmd` must stay off; a later move to the high region must clear it. A second collision is tested too: the line leaves the window one sample before expiry. Random segments mix both collisions against a cycle model built from the requirements.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;

  typedef enum logic [1:0] {
    CMD_LOW  = 2'b00,
    CMD_HIGH = 2'b01,
    CMD_OFF  = 2'b10
  } cmd_e;

  typedef enum logic [1:0] {
    RG_LOW,
    RG_HIGH,
    RG_MID,
    RG_BAD
  } region_e;

  function automatic region_e classify(input logic above_lo, input logic below_hi);
    case ({above_lo, below_hi})
      2'b01:   return RG_LOW;
      2'b10:   return RG_HIGH;
      2'b11:   return RG_MID;
      default: return RG_BAD;
    endcase
  endfunction

endpackage

// File: rtl/tri_pwm_sync.sv
module tri_pwm_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
      end
    end
  endgenerate

  assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/tri_pwm_por.sv
module tri_pwm_por (
  input  logic clk,
  input  logic rst_n,
  input  logic above_rel,
  input  logic above_hold,
  output logic por_ok
);
  // Hysteresis: released by the higher level, kept by the lower one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      por_ok <= 1'b0;
    else if (por_ok) por_ok <= above_hold;
    else             por_ok <= above_rel;
  end
endmodule

// File: rtl/tri_pwm_holdoff.sv
module tri_pwm_holdoff
  import tri_pwm_pkg::*;
#(
  parameter int HOLD_CYC = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_ok,
  input  logic above_lo,
  input  logic below_hi,
  output cmd_e cmd_q
);
  localparam int CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt;
  region_e       rg;

  assign rg = classify(above_lo, below_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_OFF;
      cnt   <= '0;
    end else if (!por_ok) begin
      cmd_q <= CMD_OFF;
      cnt   <= '0;
    end else begin
      case (rg)
        RG_LOW: begin
          cmd_q <= CMD_LOW;
          cnt   <= '0;
        end
        RG_HIGH: begin
          cmd_q <= CMD_HIGH;
          cnt   <= '0;
        end
        RG_MID: begin
          if (cmd_q != CMD_OFF) begin
            if (cnt == LAST) begin
              cmd_q <= CMD_OFF;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: cnt <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tri_pwm_decoder.sv
module tri_pwm_decoder
  import tri_pwm_pkg::*;
#(
  parameter int HOLD_CYC    = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_above_lo,
  input  logic       cmp_below_hi,
  input  logic       sup_above_rel,
  input  logic       sup_above_hold,
  output logic [1:0] cmd,
  output logic       hs_on,
  output logic       ls_on
);
  localparam int NFLAG = 4;

  logic [NFLAG-1:0] raw_flags;
  logic [NFLAG-1:0] syn_flags;
  logic syn_above_lo, syn_below_hi, syn_rel, syn_hold;
  logic por_ok;
  cmd_e cmd_q;
  cmd_e cmd_eff;

  assign raw_flags = {sup_above_hold, sup_above_rel, cmp_below_hi, cmp_above_lo};

  tri_pwm_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_flags), .q(syn_flags)
  );

  assign syn_above_lo = syn_flags[0];
  assign syn_below_hi = syn_flags[1];
  assign syn_rel      = syn_flags[2];
  assign syn_hold     = syn_flags[3];

  tri_pwm_por u_por (
    .clk(clk), .rst_n(rst_n), .above_rel(syn_rel), .above_hold(syn_hold), .por_ok(por_ok)
  );

  tri_pwm_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok),
    .above_lo(syn_above_lo), .below_hi(syn_below_hi), .cmd_q(cmd_q)
  );

  assign cmd_eff = por_ok ? cmd_q : CMD_OFF;
  assign cmd     = cmd_eff;
  assign hs_on   = (cmd_eff == CMD_HIGH);
  assign ls_on   = (cmd_eff == CMD_LOW);
endmodule

// File: rtl/tri_pwm_decoder_chk.sv
module tri_pwm_decoder_chk #(
  parameter int HOLD_CYC = 18
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cmd,
  input logic       hs_on,
  input logic       ls_on,
  input logic       por_ok,
  input logic       syn_above_lo,
  input logic       syn_below_hi
);
  localparam int CW = $clog2(HOLD_CYC + 1) + 1;
  localparam logic [CW-1:0] SAT = CW'(HOLD_CYC);

  // Consecutive window samples seen with the supply gate open, saturating.
  logic [CW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    run_q <= '0;
    else if (por_ok && syn_above_lo && syn_below_hi) run_q <= (run_q >= SAT) ? SAT : run_q + 1'b1;
    else                                           run_q <= '0;
  end

  a_r1_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));

  a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok |-> (cmd == 2'b10 && !hs_on && !ls_on));

  a_r3_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    (por_ok && cmd == 2'b10 && $past(cmd) != 2'b10) |-> (run_q >= SAT));

  a_r3_must_off: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q >= SAT) |-> (cmd == 2'b10));

  a_r5_exit_low: assert property (@(posedge clk) disable iff (!rst_n)
    (por_ok && !syn_above_lo && syn_below_hi) |=> (cmd == 2'b00 || !por_ok));

  a_r5_exit_high: assert property (@(posedge clk) disable iff (!rst_n)
    (por_ok && syn_above_lo && !syn_below_hi) |=> (cmd == 2'b01 || !por_ok));
endmodule

bind tri_pwm_decoder tri_pwm_decoder_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .hs_on(hs_on), .ls_on(ls_on),
  .por_ok(por_ok), .syn_above_lo(syn_above_lo), .syn_below_hi(syn_below_hi)
);

// File: tb/test_tri_pwm_decoder.sv
`timescale 1ns/1ps
module test_tri_pwm_decoder;
  localparam int HOLD = 18;
  localparam time TCK = 20ns;
  localparam logic [1:0] C_LOW = 2'b00, C_HIGH = 2'b01, C_OFF = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic above_lo = 1'b0, below_hi = 1'b1, sup_rel = 1'b0, sup_hold = 1'b0;
  logic [1:0] cmd;
  logic hs_on, ls_on;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(TCK/2) clk = ~clk;

  tri_pwm_decoder #(.HOLD_CYC(HOLD)) i_tri_pwm_decoder (
    .clk(clk), .rst_n(rst_n), .cmp_above_lo(above_lo), .cmp_below_hi(below_hi),
    .sup_above_rel(sup_rel), .sup_above_hold(sup_hold),
    .cmd(cmd), .hs_on(hs_on), .ls_on(ls_on)
  );

  // Cycle model written from the requirements.
  logic [3:0] m_s1, m_s2;
  logic m_por;
  logic [1:0] m_cmd;
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_por <= 1'b0; m_cmd <= C_OFF; m_cnt <= 0;
    end else begin
      m_s1 <= {sup_hold, sup_rel, below_hi, above_lo};
      m_s2 <= m_s1;
      m_por <= m_por ? m_s2[3] : m_s2[2];
      if (!m_por) begin
        m_cmd <= C_OFF; m_cnt <= 0;
      end else begin
        case (m_s2[1:0])
          2'b10: begin m_cmd <= C_LOW;  m_cnt <= 0; end
          2'b01: begin m_cmd <= C_HIGH; m_cnt <= 0; end
          2'b11: if (m_cmd != C_OFF) begin
                   if (m_cnt + 1 >= HOLD) begin m_cmd <= C_OFF; m_cnt <= 0; end
                   else m_cnt <= m_cnt + 1;
                 end
          default: m_cnt <= 0;
        endcase
      end
    end
  end

  function automatic logic [1:0] model_exp();
    return m_por ? m_cmd : C_OFF;
  endfunction

  task automatic chk(input string tag, input logic [1:0] exp);
    n_tests++;
    if (cmd !== exp || hs_on !== (exp == C_HIGH) || ls_on !== (exp == C_LOW)) begin
      n_fail++;
      $display("FAIL %s: cmd=%b hs=%b ls=%b expected cmd=%b", tag, cmd, hs_on, ls_on, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic line(input logic lo, input logic hi);
    above_lo = lo; below_hi = hi;
  endtask

  initial begin
    tick(3);
    chk("R7 reset state", C_OFF);
    rst_n = 1'b1;
    tick(5);
    chk("R7 gate closed after reset", C_OFF);

    sup_rel = 1; sup_hold = 1;
    tick(3); chk("R9 off one extra edge at release", C_OFF);
    tick(1); chk("R9 follows low after release", C_LOW);

    line(1, 0);
    tick(2); chk("R2 latency not yet", C_LOW);
    tick(1); chk("R2 high after three edges", C_HIGH);
    chk("R1 high code and enable", 2'b01);

    // Window stay one short of the holdoff.
    line(1, 1);
    for (int k = 1; k <= HOLD + 4; k++) begin
      tick(1);
      chk("R3 short window keeps high", C_HIGH);
      if (k == HOLD - 1) line(1, 0);
    end

    // Full holdoff.
    line(1, 1);
    for (int k = 1; k <= HOLD + 1; k++) begin
      tick(1); chk("R3 high held during holdoff", C_HIGH);
    end
    tick(1); chk("R3 off at expiry", C_OFF);
    tick(3); chk("R3 off held", C_OFF);

    line(0, 1);
    tick(2); chk("R5 exit not yet", C_OFF);
    tick(1); chk("R5 exit to low without holdoff", C_LOW);

    // Restart by a low sample.
    line(1, 1); tick(HOLD - 1);
    line(0, 1); tick(1);
    line(1, 1); tick(HOLD - 1);
    chk("R4 count restarted", C_LOW);
    line(0, 1); tick(4);
    chk("R4 still low", C_LOW);

    // Restart by the impossible pair.
    line(1, 1); tick(HOLD - 2);
    line(0, 0); tick(1);
    line(1, 1); tick(HOLD - 2);
    chk("R6 bad pair restarts count", C_LOW);
    line(0, 1); tick(4);
    line(1, 0); tick(3); chk("R2 to high", C_HIGH);
    line(0, 0); tick(5); chk("R6 bad pair keeps high", C_HIGH);
    line(1, 0);

    // Supply dip and hysteresis.
    sup_hold = 0; sup_rel = 0;
    tick(2); chk("R8 drop latency", C_HIGH);
    tick(1); chk("R8 off after hold drop", C_OFF);
    sup_hold = 1;
    tick(6); chk("R8 hold alone does not release", C_OFF);
    sup_rel = 1;
    tick(3); chk("R9 extra off edge", C_OFF);
    tick(1); chk("R9 resumes high", C_HIGH);
    sup_rel = 0;
    tick(5); chk("R8 stays released between levels", C_HIGH);

    // Collision: gate drop lands on holdoff expiry edge.
    sup_rel = 1;
    line(1, 1);
    for (int k = 1; k <= HOLD + 5; k++) begin
      tick(1);
      if (k <= HOLD + 1) chk("R3 collision pre-expiry", C_HIGH);
      else               chk("R8 collision off", C_OFF);
      if (k == HOLD - 1) begin sup_hold = 0; sup_rel = 0; end
    end
    sup_hold = 1; sup_rel = 1;
    tick(8); chk("R9 window at release stays off", C_OFF);
    line(1, 0);
    tick(3); chk("R9 leaves off on high", C_HIGH);

    // Random segments against the model.
    void'($urandom(32'd1234));
    for (int seg = 0; seg < 220; seg++) begin
      int r = $urandom_range(0, 19);
      int len = $urandom_range(1, 2 * HOLD + 4);
      if (r < 6)       line(0, 1);
      else if (r < 12) line(1, 0);
      else if (r < 18) line(1, 1);
      else             line(0, 0);
      if ($urandom_range(0, 19) == 0) begin
        sup_hold = ~sup_hold; sup_rel = sup_hold & $urandom_range(0, 1);
      end else if (!sup_hold) begin
        sup_hold = 1; sup_rel = 1;
      end
      for (int i = 0; i < len; i++) begin
        tick(1);
        chk("R3 R5 random vs model", model_exp());
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(TCK * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule